// File: doc/BRIEF.md
# Cascadable Display-Data Capture Front End

This block is the digital front end of a column driver meant to be chained with identical devices. When the start pin that is currently acting as an input is sampled high, the block captures one bus word per clock for a fixed number of clocks. Each bus word carries six 6-bit dots, and the block places them into a wide data register, filling it either from the first output toward the last or the other way round. Each half of the bus can be bit-inverted as it is captured.

A fixed number of clocks after its own start, the block raises a one-clock start pulse on the opposite pin, which starts the next device in the chain. It stops capturing by itself shortly after that. The two start pins swap roles with the direction input, and the pin used as input is never driven.

Once per line a strobe moves the data register into a holding latch and clears the capture position. When the strobe goes low again, the held codes are presented on the output codes. An output-enable flag is low while the strobe is high.

Top module: `dispCapTop`

## Requirements
- R1: Bus dot d (d = 0..5) occupies `busData[6d+5:6d]`, with bit 0 as LSB. The code for output i (i = 0 is the first output) appears on `outCodes[6i+5:6i]`.
- R2: With `dirRight` high, `startRight` is the start input and `startLeft` is the cascade output. Dot d of the k-th captured word (k counted from 0) goes to output 6k+d.
- R3: With `dirRight` low, `startLeft` is the start input and `startRight` is the cascade output. Dot d of the k-th captured word goes to output 6(G-1-k)+d, where G = NUM_OUTS/6.
- R4: A start input sampled high at a rising clock edge begins capture. Bus data at that same edge is not captured. The words at the next G rising edges are captured.
- R5: The cascade output pin goes high after the G-th rising edge that follows the start edge. It stays high for exactly one clock and is low at all other times.
- R6: Capture ends after G words. At the (G+2)-th edge after the start the block goes idle, and any later bus words are ignored until the next start.
- R7: When `invLow` is high, dots 0..2 are stored bit-inverted. When `invHigh` is high, dots 3..5 are stored bit-inverted. When either control is low, its dots are stored unchanged.
- R8: At the first clock edge that sees `strobe` high after it was low, the data register is copied into the holding latch. At that same edge the capture position is cleared. The bus word at that edge and all later words are ignored until the next start.
- R9: At the first edge that sees `strobe` low after it was high, the latch is copied to `outCodes`. `outEnable` goes low at the strobe-rise edge and high at the strobe-fall edge. `outCodes` holds its previous value until the strobe-fall edge.
- R10: A start that arrives while a capture is running restarts the count from zero. Both the fill position and the cascade timing are then taken from the new start.
- R11: After reset, `outCodes` is all zero, `outEnable` is low, and the cascade output pin is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dirRight | input | 1 | Fill direction and start-pin role select |
| startRight | inout | 1 | Start input when dirRight is high, cascade output otherwise |
| startLeft | inout | 1 | Start input when dirRight is low, cascade output otherwise |
| strobe | input | 1 | Line strobe |
| busData | input | 36 | Six 6-bit dots per clock |
| invLow | input | 1 | Invert dots 0..2 on capture |
| invHigh | input | 1 | Invert dots 3..5 on capture |
| outCodes | output | NUM_OUTS*6 | Presented codes, 6 bits per output |
| outEnable | output | 1 | Outputs valid (low while strobe is high) |

## Verification
The bench checks the cascade pin on every clock from the start edge to two clocks past the halt point. A design with an off-by-one count would raise the pulse on the wrong clock or hold it for two clocks. It runs both fill directions with each inversion control on its own, so a swapped group order, a swapped half, or inverted pin roles all show up as wrong codes at specific outputs. A start issued in the middle of a capture, and a strobe that cuts a capture short and is followed by junk on the bus, catch designs that keep the old count or keep writing after the strobe. A design that updates `outCodes` at the strobe rise is caught by checking `outCodes` between the two strobe edges.

// File: rtl/dispCapPkg.sv
package dispCapPkg;
  localparam int IDX_W = 16;

  typedef struct packed {
    logic             writeEn;
    logic [IDX_W-1:0] grp;
    logic             latchEn;
    logic             showEn;
  } capStrobes_t;
endpackage

// File: rtl/dispCapCtrl.sv
module dispCapCtrl
  import dispCapPkg::*;
#(
  parameter int NUM_GRP = 80
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dirRight,
  input  logic        startIn,
  input  logic        strobe,
  output capStrobes_t strb,
  output logic        cascadeOut,
  output logic        outEnable
);
  localparam int HALT_CNT = NUM_GRP + 2;
  localparam int CNT_W    = $clog2(NUM_GRP + 3);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic             stbPrev;
  logic             stbRise;
  logic             stbFall;
  logic             inWindow;

  assign stbRise  = strobe & ~stbPrev;
  assign stbFall  = ~strobe & stbPrev;
  assign cntNext  = cnt + 1'b1;
  assign inWindow = cnt < CNT_W'(NUM_GRP);

  // strobe rise has top priority, then a fresh start, then normal capture
  always_comb begin
    strb.writeEn = active && !stbRise && !startIn && inWindow;
    strb.grp     = dirRight ? IDX_W'(cnt)
                            : IDX_W'(CNT_W'(NUM_GRP - 1) - cnt);
    strb.latchEn = stbRise;
    strb.showEn  = stbFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active     <= 1'b0;
      cnt        <= '0;
      stbPrev    <= 1'b0;
      cascadeOut <= 1'b0;
      outEnable  <= 1'b0;
    end else begin
      stbPrev    <= strobe;
      cascadeOut <= 1'b0;
      if (stbRise) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (startIn) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active) begin
        cnt <= cntNext;
        if (cntNext == CNT_W'(NUM_GRP)) cascadeOut <= 1'b1;
        if (cntNext == CNT_W'(HALT_CNT)) active <= 1'b0;
      end
      if (stbRise)      outEnable <= 1'b0;
      else if (stbFall) outEnable <= 1'b1;
    end
  end
endmodule

// File: rtl/dispCapData.sv
module dispCapData
  import dispCapPkg::*;
#(
  parameter int NUM_GRP = 80,
  parameter int DOTS    = 6,
  parameter int DOT_W   = 6
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  capStrobes_t                     strb,
  input  logic [DOTS*DOT_W-1:0]           busData,
  input  logic                            invLow,
  input  logic                            invHigh,
  output logic [NUM_GRP*DOTS*DOT_W-1:0]   regFlat,
  output logic [NUM_GRP*DOTS*DOT_W-1:0]   latchFlat,
  output logic [NUM_GRP*DOTS*DOT_W-1:0]   outCodes
);
  localparam int WORD_W = DOTS * DOT_W;
  localparam int HALF   = DOTS / 2;

  logic [WORD_W-1:0] wordIn;
  logic [WORD_W-1:0] grpReg [NUM_GRP];

  // per-dot optional inversion, lower half and upper half controlled apart
  for (genvar d = 0; d < DOTS; d++) begin : g_dot
    if (d < HALF) begin : g_lo
      assign wordIn[d*DOT_W +: DOT_W] =
        invLow ? ~busData[d*DOT_W +: DOT_W] : busData[d*DOT_W +: DOT_W];
    end else begin : g_hi
      assign wordIn[d*DOT_W +: DOT_W] =
        invHigh ? ~busData[d*DOT_W +: DOT_W] : busData[d*DOT_W +: DOT_W];
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) grpReg[g] <= '0;
      else if (strb.writeEn && (strb.grp == IDX_W'(g))) grpReg[g] <= wordIn;
    end
    assign regFlat[g*WORD_W +: WORD_W] = grpReg[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchFlat <= '0;
      outCodes  <= '0;
    end else begin
      if (strb.latchEn) latchFlat <= regFlat;
      if (strb.showEn)  outCodes  <= latchFlat;
    end
  end
endmodule

// File: rtl/dispCapTop.sv
module dispCapTop
  import dispCapPkg::*;
#(
  parameter int NUM_OUTS = 480,
  parameter int DOTS     = 6,
  parameter int DOT_W    = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      dirRight,
  inout  wire                       startRight,
  inout  wire                       startLeft,
  input  logic                      strobe,
  input  logic [DOTS*DOT_W-1:0]     busData,
  input  logic                      invLow,
  input  logic                      invHigh,
  output logic [NUM_OUTS*DOT_W-1:0] outCodes,
  output logic                      outEnable
);
  localparam int NUM_GRP = NUM_OUTS / DOTS;

  capStrobes_t                     strb;
  logic                            cascadeOut;
  logic                            startIn;
  logic [NUM_OUTS*DOT_W-1:0]       regFlat;
  logic [NUM_OUTS*DOT_W-1:0]       latchFlat;

  // the pin acting as input is released, the other carries the cascade pulse
  assign startRight = dirRight ? 1'bz : cascadeOut;
  assign startLeft  = dirRight ? cascadeOut : 1'bz;
  assign startIn    = dirRight ? startRight : startLeft;

  dispCapCtrl #(.NUM_GRP(NUM_GRP)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dirRight   (dirRight),
    .startIn    (startIn),
    .strobe     (strobe),
    .strb       (strb),
    .cascadeOut (cascadeOut),
    .outEnable  (outEnable)
  );

  dispCapData #(.NUM_GRP(NUM_GRP), .DOTS(DOTS), .DOT_W(DOT_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busData   (busData),
    .invLow    (invLow),
    .invHigh   (invHigh),
    .regFlat   (regFlat),
    .latchFlat (latchFlat),
    .outCodes  (outCodes)
  );
endmodule

// File: rtl/dispCapChk.sv
module dispCapChk
  import dispCapPkg::*;
#(
  parameter int NUM_OUTS = 480,
  parameter int DOT_W    = 6
) (
  input logic                      clk,
  input logic                      rstN,
  input capStrobes_t               strb,
  input logic                      cascadeOut,
  input logic                      outEnable,
  input logic [NUM_OUTS*DOT_W-1:0] regFlat,
  input logic [NUM_OUTS*DOT_W-1:0] latchFlat,
  input logic [NUM_OUTS*DOT_W-1:0] outCodes
);
  // R5
  cascade_one_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    cascadeOut |=> !cascadeOut);
  // R8
  latch_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchEn |=> (latchFlat == $past(regFlat)));
  // R8
  no_write_at_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchEn |=> $stable(regFlat));
  // R9
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchEn |=> !outEnable);
  // R9
  oe_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.showEn |=> outEnable);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.showEn |=> $stable(outCodes));
  // R9
  out_show_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.showEn |=> (outCodes == $past(latchFlat)));
endmodule

bind dispCapTop dispCapChk #(.NUM_OUTS(NUM_OUTS), .DOT_W(DOT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .strb       (strb),
  .cascadeOut (cascadeOut),
  .outEnable  (outEnable),
  .regFlat    (regFlat),
  .latchFlat  (latchFlat),
  .outCodes   (outCodes)
);

// File: tb/tb_dispCapTop.sv
`timescale 1ns/1ps
module tb_dispCapTop;
  localparam int NOUT = 48;
  localparam int G    = NOUT / 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              dirRight = 1'b1;
  logic              drvVal = 1'b0;
  logic              strobe = 1'b0;
  logic [35:0]       busData = '0;
  logic              invLow = 1'b0;
  logic              invHigh = 1'b0;
  logic [NOUT*6-1:0] outCodes;
  logic              outEnable;
  wire               startRight;
  wire               startLeft;

  assign startRight = dirRight ? drvVal : 1'bz;
  assign startLeft  = dirRight ? 1'bz : drvVal;

  int checks = 0;
  int errors = 0;
  logic [5:0] regModel [NOUT];
  logic [5:0] latchModel [NOUT];
  logic [5:0] outModel [NOUT];

  always #4 clk = ~clk;

  dispCapTop #(.NUM_OUTS(NOUT)) dut (
    .clk(clk), .rstN(rstN), .dirRight(dirRight),
    .startRight(startRight), .startLeft(startLeft),
    .strobe(strobe), .busData(busData), .invLow(invLow), .invHigh(invHigh),
    .outCodes(outCodes), .outEnable(outEnable)
  );

  function automatic logic [5:0] dotVal(input int seed, input int k, input int d);
    return 6'((seed * 13 + k * 7 + d * 11 + 3) % 64);
  endfunction

  function automatic logic casPin();
    return dirRight ? startLeft : startRight;
  endfunction

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic checkCodes(input string req);
    int bad = -1;
    checks++;
    for (int i = 0; i < NOUT; i++)
      if (bad < 0 && outCodes[i*6 +: 6] !== outModel[i]) bad = i;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: output %0d actual %h expected %h",
               req, bad, outCodes[bad*6 +: 6], outModel[bad]);
    end
  endtask

  // called right after a falling edge; ends right after a falling edge
  task automatic capture(input bit dir, input int nWords, input int seed, input bit casCheck);
    dirRight = dir;
    drvVal   = 1'b1;
    busData  = '1;             // R4: data at the start edge must not be stored
    @(negedge clk);
    drvVal = 1'b0;
    for (int k = 1; k <= nWords; k++) begin
      for (int d = 0; d < 6; d++) begin
        logic [5:0] v;
        v = dotVal(seed, k - 1, d);
        busData[d*6 +: 6] = v;
        if (k <= G) begin    // R6: words past G are not modelled
          if ((d < 3 && invLow) || (d >= 3 && invHigh)) v = ~v;
          if (dir) regModel[6*(k-1) + d] = v;
          else     regModel[6*(G-k) + d] = v;
        end
      end
      @(negedge clk);
      if (casCheck) checkBit($sformatf("R5 cascade k=%0d", k), casPin(), k == G);
    end
  endtask

  task automatic doStrobe(input string req);
    strobe = 1'b1;
    @(negedge clk);
    checkBit({req, " R9 oe low"}, outEnable, 1'b0);
    checkCodes({req, " R9 hold"});
    for (int i = 0; i < NOUT; i++) latchModel[i] = regModel[i];
    strobe = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NOUT; i++) outModel[i] = latchModel[i];
    checkBit({req, " R9 oe high"}, outEnable, 1'b1);
    checkCodes(req);
  endtask

  task automatic testReset();
    for (int i = 0; i < NOUT; i++) outModel[i] = '0;
    checkCodes("R11 codes");
    checkBit("R11 oe", outEnable, 1'b0);
    checkBit("R11 cascade pin", casPin(), 1'b0);
  endtask

  task automatic testRight();
    invLow = 0; invHigh = 0;
    capture(1'b1, G, 1, 1'b1);
    doStrobe("R2 R4 R1 right fill");
  endtask

  task automatic testLeftInvLow();
    invLow = 1; invHigh = 0;
    capture(1'b0, G, 2, 1'b1);
    doStrobe("R3 R7 left fill low inversion");
  endtask

  task automatic testHaltInvHigh();
    invLow = 0; invHigh = 1;
    capture(1'b1, G + 4, 3, 1'b1);
    doStrobe("R6 R7 halt and high inversion");
  endtask

  task automatic testRestart();
    invLow = 1; invHigh = 1;
    capture(1'b0, 3, 4, 1'b0);
    capture(1'b0, G + 2, 5, 1'b1);
    doStrobe("R10 restart");
  endtask

  task automatic testStrobeClear();
    invLow = 0; invHigh = 0;
    capture(1'b1, 3, 6, 1'b0);
    busData = 36'hA5A5A5A5A;
    doStrobe("R8 cut short");
    for (int k = 0; k < G + 3; k++) begin
      busData = 36'(k * 36'h111111111);
      @(negedge clk);
      checkBit("R8 no cascade after clear", casPin(), 1'b0);
    end
    doStrobe("R8 junk ignored");
  endtask

  initial begin
    for (int i = 0; i < NOUT; i++) begin
      regModel[i] = '0; latchModel[i] = '0; outModel[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRight();
    testLeftInvLow();
    testHaltInvHigh();
    testRestart();
    testStrobeClear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule